// File: doc/BRIEF.md
# Producer-Consumer Latency Interlock

This block sits at the issue stage of an in-order pipeline and decides whether the instruction being presented may leave this cycle. It keeps, for every tracked register, how many cycles are left before that register's pending result can be consumed. The wait is held separately for four kinds of consumer: use as a load/store address, use as store data, general execute use (which also covers reading the hi/lo pair), and use by a multiply or divide. The latency a producer leaves behind therefore depends on both the producing class and the way a later instruction reads it.

At an accepted issue the producer's class selects a four-field latency record, and that record is loaded into the destination's countdowns. Multiplies always write both halves of the hi/lo pair. Each source of a presented instruction names a register and a consumer kind; if the selected countdown has not reached zero, the block raises `stall` and records nothing for that instruction. Unit selection and the datapaths are handled elsewhere.

Top module: `lat_interlock`

## Requirements
- R1: After reset no register has a pending write, so no source of any kind on any entry (0 to NUM_REGS+1) causes a stall.
- R2: If a producer of latency L for consumer kind K is accepted in cycle t, a consumer of that register with kind K presented in cycle t+k (k >= 1) stalls exactly when k < L; latencies of 0 and 1 never stall. Kind codes: 0 address, 1 store data, 2 general (and hi/lo read), 3 multiply/divide use.
- R3: Producer class 0 (integer ALU, shift, hi/lo read on an integer pipe) has latency 5 to address use and 1 to the other three kinds.
- R4: Producer class 1 (load) has latency 3 to address use, 0 to store data, and 1 to general and multiply/divide use.
- R5: Producer classes 2 (32-bit multiply) and 3 (64-bit multiply) ignore the destination field and write entry NUM_REGS (hi) and entry NUM_REGS+1 (lo). Both have address latency 7; other kinds are 3, except the 64-bit hi entry, which is 4.
- R6: Producer class 4 (move to hi or lo, destination chosen by the destination field) has latency 3 to general/hi-lo read and 4 to address, store data and multiply/divide use.
- R7: Producer class 5 (move into an FP register) has latency 5 and class 6 (move out of an FP register) latency 1, for every kind.
- R8: Classes 7 to 12 (basic FP op, FP multiply-add, single divide, double divide, single square root, double square root) have latencies 4, 8, 24, 32, 28 and 40 for every kind; the unused codes 13 to 15 have latency 1.
- R9: A record is written only on an accepted issue: a stalled or non-valid issue, or one with the destination-valid bit low (non-multiply), leaves every entry unchanged.
- R10: A newer accepted write to an entry replaces its pending countdowns, even when the new latency is shorter.
- R11: Sources whose valid bit is low are ignored, and `stall` is low whenever `iss_valid` is low.
- R12: A source that names the instruction's own destination is checked against the old state; the new record takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_prod | input | 4 | Producer class of the presented instruction |
| iss_dst_valid | input | 1 | The instruction writes `iss_dst` |
| iss_dst | input | IDX_W (5) | Destination entry; NUM_REGS is hi, NUM_REGS+1 is lo |
| iss_src_valid | input | NUM_SRCS (2) | Per-source valid bits |
| iss_src_idx | input | NUM_SRCS*IDX_W (10) | Packed source entry indices, source 0 in the low slice |
| iss_src_kind | input | NUM_SRCS*2 (4) | Packed consumer kinds, source 0 in the low slice |
| stall | output | 1 | The presented instruction must wait this cycle |

## Verification
The assertions assume the issue inputs are stable across each clock edge and that destination and source indices stay below NUM_REGS+2; the bench drives all inputs on the falling edge and only names existing entries. The countdown checks also assume that a stalled instruction is held off by the caller rather than forced through, which the bench respects by never treating a stalled probe as issued. The main sweep crosses every producer code with every consumer kind on a general register, the hi entry and the lo entry, probing each cycle after the producer until all windows have closed.

// File: rtl/lat_pkg.sv
package lat_pkg;

    localparam int CNT_W  = 6;
    localparam int KIND_W = 2;
    localparam int PROD_W = 4;

    typedef enum logic [PROD_W-1:0] {
        PC_ALU     = 4'd0,
        PC_LOAD    = 4'd1,
        PC_MUL32   = 4'd2,
        PC_MUL64   = 4'd3,
        PC_MTHILO  = 4'd4,
        PC_TOFP    = 4'd5,
        PC_FROMFP  = 4'd6,
        PC_FPOP    = 4'd7,
        PC_FMADD   = 4'd8,
        PC_FDIVS   = 4'd9,
        PC_FDIVD   = 4'd10,
        PC_FSQRTS  = 4'd11,
        PC_FSQRTD  = 4'd12
    } prod_cls_e;

    typedef enum logic [KIND_W-1:0] {
        UK_ADDR = 2'd0,
        UK_DATA = 2'd1,
        UK_GEN  = 2'd2,
        UK_ACC  = 2'd3
    } use_kind_e;

    typedef struct packed {
        logic [CNT_W-1:0] addr;
        logic [CNT_W-1:0] data;
        logic [CNT_W-1:0] gen;
        logic [CNT_W-1:0] acc;
    } ready_rec_t;

    function automatic ready_rec_t mk_rec(int a, int d, int g, int c);
        ready_rec_t r;
        r.addr = CNT_W'(a);
        r.data = CNT_W'(d);
        r.gen  = CNT_W'(g);
        r.acc  = CNT_W'(c);
        return r;
    endfunction

    function automatic ready_rec_t flat_rec(int l);
        return mk_rec(l, l, l, l);
    endfunction

    // Latency record for a producer class; for_lo selects the lo half of a
    // 64-bit multiply, which becomes readable one cycle before hi.
    function automatic ready_rec_t lat_of(logic [PROD_W-1:0] code, logic for_lo);
        ready_rec_t r;
        case (code)
            PC_ALU:    r = mk_rec(5, 1, 1, 1);
            PC_LOAD:   r = mk_rec(3, 0, 1, 1);
            PC_MUL32:  r = mk_rec(7, 3, 3, 3);
            PC_MUL64:  r = for_lo ? mk_rec(7, 3, 3, 3) : mk_rec(7, 4, 4, 4);
            PC_MTHILO: r = mk_rec(4, 4, 3, 4);
            PC_TOFP:   r = flat_rec(5);
            PC_FROMFP: r = flat_rec(1);
            PC_FPOP:   r = flat_rec(4);
            PC_FMADD:  r = flat_rec(8);
            PC_FDIVS:  r = flat_rec(24);
            PC_FDIVD:  r = flat_rec(32);
            PC_FSQRTS: r = flat_rec(28);
            PC_FSQRTD: r = flat_rec(40);
            default:   r = flat_rec(1);
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] pick_field(ready_rec_t r, logic [KIND_W-1:0] k);
        logic [CNT_W-1:0] v;
        case (k)
            UK_ADDR: v = r.addr;
            UK_DATA: v = r.data;
            UK_GEN:  v = r.gen;
            default: v = r.acc;
        endcase
        return v;
    endfunction

    // A latency of L allows the consumer L cycles after the producer, so the
    // countdown starts at L-1; zero stays zero.
    function automatic logic [CNT_W-1:0] to_count(logic [CNT_W-1:0] l);
        return (l == '0) ? '0 : l - 1'b1;
    endfunction

    function automatic logic is_mul(logic [PROD_W-1:0] code);
        return (code == PC_MUL32) || (code == PC_MUL64);
    endfunction

endpackage

// File: rtl/lat_table.sv
module lat_table
    import lat_pkg::*;
(
    input  logic [PROD_W-1:0] prod_code,
    output ready_rec_t        rec_main,
    output ready_rec_t        rec_lo,
    output logic              writes_pair
);
    always_comb begin
        rec_main    = lat_of(prod_code, 1'b0);
        rec_lo      = lat_of(prod_code, 1'b1);
        writes_pair = is_mul(prod_code);
    end
endmodule

// File: rtl/lat_entry.sv
module lat_entry
    import lat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  ready_rec_t wr_rec,
    output ready_rec_t remain
);
    function automatic logic [CNT_W-1:0] step(logic [CNT_W-1:0] c);
        return (c == '0) ? '0 : c - 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (wr_en) begin
            remain.addr <= to_count(wr_rec.addr);
            remain.data <= to_count(wr_rec.data);
            remain.gen  <= to_count(wr_rec.gen);
            remain.acc  <= to_count(wr_rec.acc);
        end else begin
            remain.addr <= step(remain.addr);
            remain.data <= step(remain.data);
            remain.gen  <= step(remain.gen);
            remain.acc  <= step(remain.acc);
        end
    end

    // R2: without a new write a pending wait shrinks by exactly one per cycle
    assert_countdown_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && remain.gen != '0) |=> remain.gen == $past(remain.gen) - 1'b1);

    // R1: an entry with nothing pending stays ready until written
    assert_idle_stays_ready_R1: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && remain == '0) |=> remain == '0);

    // R4: store-data use is never held longer than address use
    assert_data_not_after_addr_R4: assert property (@(posedge clk) disable iff (rst)
        remain.data <= remain.addr);

    // R10: a write always replaces the pending wait with the new record
    assert_rewrite_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> remain.acc == to_count($past(wr_rec.acc)));
endmodule

// File: rtl/src_check.sv
module src_check
    import lat_pkg::*;
#(
    parameter int NUM_ENTRIES = 18,
    parameter int IDX_W       = 5
)(
    input  ready_rec_t        remain_all [NUM_ENTRIES],
    input  logic              src_valid,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [KIND_W-1:0] src_kind,
    output logic              busy
);
    ready_rec_t sel;

    always_comb begin
        sel = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (src_idx == IDX_W'(e)) sel = remain_all[e];
        end
        busy = src_valid && (pick_field(sel, src_kind) != '0);
    end
endmodule

// File: rtl/lat_interlock.sv
module lat_interlock
    import lat_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int NUM_SRCS = 2,
    parameter int IDX_W    = $clog2(NUM_REGS + 2)
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       iss_valid,
    input  logic [3:0]                 iss_prod,
    input  logic                       iss_dst_valid,
    input  logic [IDX_W-1:0]           iss_dst,
    input  logic [NUM_SRCS-1:0]        iss_src_valid,
    input  logic [NUM_SRCS*IDX_W-1:0]  iss_src_idx,
    input  logic [NUM_SRCS*2-1:0]      iss_src_kind,
    output logic                       stall
);
    localparam int NUM_ENTRIES = NUM_REGS + 2;
    localparam int HI_IDX      = NUM_REGS;
    localparam int LO_IDX      = NUM_REGS + 1;

    ready_rec_t              remain_all [NUM_ENTRIES];
    ready_rec_t              wr_rec     [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0]  wr_en;
    logic [NUM_SRCS-1:0]     src_busy;
    ready_rec_t              rec_main;
    ready_rec_t              rec_lo;
    logic                    writes_pair;
    logic                    accept;

    lat_table u_table (
        .prod_code   (iss_prod),
        .rec_main    (rec_main),
        .rec_lo      (rec_lo),
        .writes_pair (writes_pair)
    );

    for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
        src_check #(
            .NUM_ENTRIES (NUM_ENTRIES),
            .IDX_W       (IDX_W)
        ) u_chk (
            .remain_all (remain_all),
            .src_valid  (iss_src_valid[s]),
            .src_idx    (iss_src_idx[s*IDX_W +: IDX_W]),
            .src_kind   (iss_src_kind[s*KIND_W +: KIND_W]),
            .busy       (src_busy[s])
        );
    end

    assign stall  = iss_valid && (|src_busy);
    assign accept = iss_valid && !(|src_busy);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        localparam bit IS_PAIR = (e == HI_IDX) || (e == LO_IDX);
        localparam bit IS_LO   = (e == LO_IDX);

        always_comb begin
            if (writes_pair)
                wr_en[e] = accept && IS_PAIR;
            else
                wr_en[e] = accept && iss_dst_valid && (iss_dst == IDX_W'(e));
            wr_rec[e] = (writes_pair && IS_LO) ? rec_lo : rec_main;
        end

        lat_entry u_entry (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en[e]),
            .wr_rec (wr_rec[e]),
            .remain (remain_all[e])
        );
    end

    // R11: a stall needs both a presented instruction and a valid source
    assert_stall_needs_request_R11: assert property (@(posedge clk) disable iff (rst)
        stall |-> (iss_valid && (|iss_src_valid)));

    // R9: nothing is recorded unless the instruction actually leaves
    assert_write_only_on_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (!iss_valid || stall) |-> (wr_en == '0));

    // R5: an accepted multiply records exactly the hi and lo entries
    assert_mul_pair_R5: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !stall && (iss_prod == PC_MUL32 || iss_prod == PC_MUL64))
            |-> ($countones(wr_en) == 2 && wr_en[HI_IDX] && wr_en[LO_IDX]));

    // R9: at most one register is written by a non-multiply
    assert_single_dst_R9: assert property (@(posedge clk) disable iff (rst)
        !(iss_prod == PC_MUL32 || iss_prod == PC_MUL64) |-> $onehot0(wr_en));
endmodule

// File: tb/lat_interlock_tb.sv
module lat_interlock_tb;
    localparam int NUM_REGS = 16;
    localparam int IDX_W    = 5;
    localparam int HI       = NUM_REGS;
    localparam int LO       = NUM_REGS + 1;

    logic             clk = 1'b0;
    logic             rst;
    logic             iss_valid;
    logic [3:0]       iss_prod;
    logic             iss_dst_valid;
    logic [IDX_W-1:0] iss_dst;
    logic [1:0]       iss_src_valid;
    logic [2*IDX_W-1:0] iss_src_idx;
    logic [3:0]       iss_src_kind;
    logic             stall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lat_interlock u_dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_prod(iss_prod),
        .iss_dst_valid(iss_dst_valid), .iss_dst(iss_dst),
        .iss_src_valid(iss_src_valid), .iss_src_idx(iss_src_idx),
        .iss_src_kind(iss_src_kind), .stall(stall)
    );

    // Latency from the requirements: producer p, kind u, observed entry tgt.
    function automatic int spec_lat(int p, int u, int tgt);
        if (p == 2 || p == 3) begin
            if (tgt != HI && tgt != LO) return 0;
            if (u == 0) return 7;
            if (p == 3 && tgt == HI) return 4;
            return 3;
        end
        case (p)
            0: return (u == 0) ? 5 : 1;
            1: return (u == 0) ? 3 : ((u == 1) ? 0 : 1);
            4: return (u == 2) ? 3 : 4;
            5: return 5;
            6: return 1;
            7: return 4;
            8: return 8;
            9: return 24;
            10: return 32;
            11: return 28;
            12: return 40;
            default: return 1;
        endcase
    endfunction

    function automatic string req_of(int p);
        case (p)
            0: return "R3";
            1: return "R4";
            2, 3: return "R5";
            4: return "R6";
            5, 6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic idle();
        iss_valid = 0; iss_prod = 0; iss_dst_valid = 0; iss_dst = 0;
        iss_src_valid = 0; iss_src_idx = 0; iss_src_kind = 0;
    endtask

    task automatic check(string req, logic got, logic exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: stall=%0b expected %0b", req, what, got, exp);
        end
    endtask

    // Present a producer with no sources; call at a falling edge.
    task automatic produce(int p, int dst, bit dv);
        idle();
        iss_valid = 1; iss_prod = 4'(p); iss_dst_valid = dv; iss_dst = IDX_W'(dst);
    endtask

    // Present a consumer on one source slot, no destination.
    task automatic consume(int slot, int idx, int kind);
        idle();
        iss_valid = 1;
        iss_src_valid[slot] = 1'b1;
        iss_src_idx[slot*IDX_W +: IDX_W] = IDX_W'(idx);
        iss_src_kind[slot*2 +: 2] = 2'(kind);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: every entry, every kind ready after reset
        for (int e = 0; e < NUM_REGS + 2; e++) begin
            for (int u = 0; u < 4; u++) begin
                consume(u % 2, e, u);
                #1 check("R1", stall, 1'b0, $sformatf("entry %0d kind %0d", e, u));
                @(negedge clk);
            end
        end

        // R2..R8 sweep: producer x kind x target, probe every cycle after
        for (int ti = 0; ti < 3; ti++) begin
            for (int p = 0; p < 16; p++) begin
                for (int u = 0; u < 4; u++) begin
                    int tgt;
                    int lat;
                    tgt = (ti == 0) ? 3 : ((ti == 1) ? HI : LO);
                    lat = spec_lat(p, u, tgt);
                    produce(p, tgt, 1'b1);
                    @(negedge clk);
                    for (int k = 1; k <= 42; k++) begin
                        consume((p + u) % 2, tgt, u);
                        #1 check($sformatf("R2/%s", req_of(p)), stall, logic'(k < lat),
                                 $sformatf("p=%0d kind=%0d tgt=%0d k=%0d", p, u, tgt, k));
                        @(negedge clk);
                    end
                end
            end
        end

        // R9: a stalled instruction records nothing for its destination
        produce(10, 5, 1'b1);                  // double divide to r5
        @(negedge clk);
        produce(12, 6, 1'b1);                  // would write r6, but reads r5
        iss_src_valid[0] = 1'b1; iss_src_idx[IDX_W-1:0] = 5'd5; iss_src_kind[1:0] = 2'd2;
        #1 check("R9", stall, 1'b1, "consumer of fresh divide");
        @(negedge clk);
        consume(1, 6, 2);
        #1 check("R9", stall, 1'b0, "stalled writer left r6 ready");
        @(negedge clk);
        // R9: destination-valid low records nothing
        produce(12, 7, 1'b0);
        @(negedge clk);
        consume(0, 7, 0);
        #1 check("R9", stall, 1'b0, "dst-valid low left r7 ready");
        @(negedge clk);
        // R9: iss_valid low records nothing
        idle(); iss_prod = 4'd12; iss_dst_valid = 1; iss_dst = 5'd8;
        @(negedge clk);
        consume(0, 8, 2);
        #1 check("R9", stall, 1'b0, "non-valid issue left r8 ready");
        @(negedge clk);

        // R10: shorter write replaces a long pending one
        produce(12, 9, 1'b1);
        @(negedge clk);
        produce(0, 9, 1'b1);                   // ALU: general latency 1
        @(negedge clk);
        consume(0, 9, 2);
        #1 check("R10", stall, 1'b0, "ALU overwrite of sqrt on r9 general");
        @(negedge clk);
        consume(1, 9, 0);
        #1 check("R10", stall, 1'b1, "ALU overwrite address window k=2");
        @(negedge clk);

        // R11: invalid source and non-valid issue never stall
        produce(11, 10, 1'b1);
        @(negedge clk);
        consume(0, 10, 2);
        iss_src_valid = 2'b00;
        #1 check("R11", stall, 1'b0, "busy source with valid low");
        iss_src_valid = 2'b01; iss_valid = 0;
        #1 check("R11", stall, 1'b0, "busy source with iss_valid low");
        iss_valid = 1;
        #1 check("R11", stall, 1'b1, "busy source presented");
        // second source busy, first ready
        iss_src_valid = 2'b11;
        iss_src_idx = {5'd10, 5'd2}; iss_src_kind = {2'd2, 2'd2};
        #1 check("R11", stall, 1'b1, "second source busy alone");
        @(negedge clk);

        // R12: self-dependent source sees the old state
        produce(7, 11, 1'b1);
        iss_src_valid[0] = 1'b1; iss_src_idx[IDX_W-1:0] = 5'd11; iss_src_kind[1:0] = 2'd2;
        #1 check("R12", stall, 1'b0, "source equal to destination, old ready");
        @(negedge clk);
        consume(0, 11, 2);
        #1 check("R12", stall, 1'b1, "new record visible next cycle");
        @(negedge clk);

        idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule